// File: doc/BRIEF.md
# Critical-Word-First Burst Address Sequencer

This block is the master-side sequencer for one transfer on an external memory bus. A request gives a byte address, a read/write flag, a burst flag and a port-size code. The sequencer puts the address and attributes on the bus together with a one-cycle start strobe. It holds them until the slave acknowledges, then moves to the next beat or finishes.

A burst always moves one 16-byte line. The number of beats depends on the port width: four beats for a 32-bit port, eight for a 16-bit port and sixteen for an 8-bit port. The first beat carries the critical byte offset taken from the request. Each later beat adds one port width to the line offset and wraps inside the line, so the last beat lands just before the critical one. Address bits above the line offset do not change during a burst. A one-cycle done pulse follows the final acknowledge.

The 26-bit bus address is a plain vector in which index 0 is the least significant byte address bit, so the line offset is bits [3:0].

Top module: `cwf_burst_seq`

## Requirements
- R1: While synchronous active-high `rst` is high, and in the first cycle after it falls, `bus_active`, `bus_start` and `xfer_done` are 0 and `bus_addr`, `bus_read` and `bus_burst` are 0.
- R2: A request sampled with `req_valid` high while idle makes `bus_active` high from the next cycle. The address and attributes are then driven and stay unchanged in every cycle where `bus_ack` was low at the previous edge.
- R3: `bus_read` is 1 for a read and 0 for a write, copied from `req_read`. `bus_burst` is copied from `req_burst` and stays high for every beat of a burst.
- R4: `bus_start` is high for exactly the first cycle of each transfer, and only then. A `req_valid` seen while `bus_active` is high is ignored: it starts no transfer and does not change the address or attributes.
- R5: The port-size code sets the beat count of a burst: 2'b00 means a 32-bit port with 4 beats, 2'b10 a 16-bit port with 8 beats, 2'b01 an 8-bit port with 16 beats. The code 2'b11 behaves as 2'b00.
- R6: On beat k of a burst, `bus_addr[3:0]` equals (critical offset + k × port bytes) mod 16, and `bus_addr[25:4]` equals the request's upper bits. The beat index advances only on an edge where `bus_ack` is high.
- R7: A transfer with `req_burst` low has exactly one beat at the full requested address and ends on its first acknowledge.
- R8: `xfer_done` is high for exactly the one cycle after the final acknowledge, with `bus_active` low in that cycle. A request presented in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request, taken only while idle |
| req_addr | input | 26 | Start byte address; bits [3:0] are the critical line offset |
| req_read | input | 1 | 1 = read, 0 = write |
| req_burst | input | 1 | 1 = burst over one 16-byte line |
| req_psize | input | 2 | Port size: 00 = 32-bit, 10 = 16-bit, 01 = 8-bit, 11 = as 00 |
| bus_ack | input | 1 | Slave acknowledge of the current beat |
| bus_addr | output | 26 | Address of the current beat, 0 when idle |
| bus_read | output | 1 | Read/write attribute, 0 when idle |
| bus_burst | output | 1 | Burst attribute, 0 when idle |
| bus_start | output | 1 | One-cycle start strobe for each transfer |
| bus_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse after the final acknowledge |

## Verification
The bench uses critical offsets that wrap at different points: offset 8 on a 32-bit port, offset 6 on a 16-bit port and offset 15 on an 8-bit port. A sequencer that counts up from zero, or that masks with the wrong width, puts out a wrong offset on a later beat. A slow acknowledge pattern exposes a counter that steps on every clock instead of on acknowledge, because the held address would change too early. Garbage requests during a busy transfer catch a design that takes them and restarts, and a reserved size code catches a wrong default beat count. Back-to-back transfers issued in the done cycle catch a design that needs an extra idle cycle.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  typedef enum logic [1:0] {
    PS_W32 = 2'b00,
    PS_W8  = 2'b01,
    PS_W16 = 2'b10,
    PS_RSV = 2'b11
  } port_size_e;

  // bytes moved per beat for a port-size code; reserved code acts as 32-bit
  function automatic int unsigned port_bytes(input logic [1:0] ps);
    case (ps)
      PS_W8:   return 1;
      PS_W16:  return 2;
      default: return 4;
    endcase
  endfunction

  // beats in one transfer: a whole line for bursts, one otherwise
  function automatic int unsigned beat_count(input logic burst, input logic [1:0] ps,
                                             input int unsigned line_bytes);
    if (burst) return line_bytes / port_bytes(ps);
    return 1;
  endfunction

  // line offset of a beat, wrapping from the critical byte
  function automatic int unsigned wrap_offset(input int unsigned crit, input int unsigned beat,
                                              input int unsigned bytes, input int unsigned line_bytes);
    return (crit + beat * bytes) % line_bytes;
  endfunction

endpackage

// File: rtl/cwf_ctl.sv
module cwf_ctl (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic ack,
  input  logic last,
  output logic accept,
  output logic beat_adv,
  output logic finish,
  output logic busy,
  output logic start,
  output logic done
);
  logic busy_q, start_q, done_q;

  assign accept   = !busy_q && req_valid;
  assign beat_adv = busy_q && ack && !last;
  assign finish   = busy_q && ack && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (accept)      busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      start_q <= accept;
      done_q  <= finish;
    end
  end

  assign busy  = busy_q;
  assign start = start_q;
  assign done  = done_q;

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (rst) start_q |=> !start_q);
  // R4
  start_in_busy_chk: assert property (@(posedge clk) disable iff (rst) start_q |-> busy_q);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q);
  // R8
  done_after_finish_chk: assert property (@(posedge clk) disable iff (rst) finish |=> done_q && !busy_q);

endmodule

// File: rtl/cwf_beat_ctr.sv
module cwf_beat_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] limit_in,
  input  logic             adv,
  output logic [CNT_W-1:0] beat,
  output logic             last
);
  logic [CNT_W-1:0] beat_q, limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q  <= '0;
      limit_q <= '0;
    end else if (load) begin
      beat_q  <= '0;
      limit_q <= limit_in;
    end else if (adv) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign beat = beat_q;
  assign last = (beat_q == limit_q);

  // R6
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv |=> beat_q == CNT_W'($past(beat_q) + 1'b1));
  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv && !load |=> $stable(beat_q));
  // R5
  beat_bound_chk: assert property (@(posedge clk) disable iff (rst) beat_q <= limit_q);

endmodule

// File: rtl/cwf_addr_gen.sv
module cwf_addr_gen
  import cwf_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 16,
  parameter int OFS_W      = $clog2(LINE_BYTES),
  parameter int CNT_W      = OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_read,
  input  logic              req_burst,
  input  logic [1:0]        req_psize,
  input  logic              active,
  input  logic              ack,
  input  logic              last,
  input  logic [CNT_W-1:0]  beat,
  output logic [CNT_W-1:0]  limit,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_read,
  output logic              bus_burst
);
  logic [ADDR_W-1:0] addr_q;
  logic              read_q, burst_q;
  logic [1:0]        ps_q;
  logic [OFS_W-1:0]  line_ofs;
  logic [ADDR_W-OFS_W-1:0] line_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      read_q  <= 1'b0;
      burst_q <= 1'b0;
      ps_q    <= 2'b00;
    end else if (load) begin
      addr_q  <= req_addr;
      read_q  <= req_read;
      burst_q <= req_burst;
      ps_q    <= req_psize;
    end
  end

  assign limit     = CNT_W'(beat_count(req_burst, req_psize, LINE_BYTES) - 1);
  assign line_ofs  = OFS_W'(wrap_offset(32'(addr_q[OFS_W-1:0]), 32'(beat),
                                        port_bytes(ps_q), LINE_BYTES));
  assign line_base = addr_q[ADDR_W-1:OFS_W];

  assign bus_addr  = active ? {line_base, line_ofs} : '0;
  assign bus_read  = active && read_q;
  assign bus_burst = active && burst_q;

  // R2
  attr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    active && !ack |=> $stable(bus_addr) && $stable(bus_read) && $stable(bus_burst));
  // R6
  line_base_chk: assert property (@(posedge clk) disable iff (rst)
    active && ack && !last |=> $stable(bus_addr[ADDR_W-1:OFS_W]));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !active |-> bus_addr == '0 && !bus_read && !bus_burst);

endmodule

// File: rtl/cwf_burst_seq.sv
module cwf_burst_seq #(
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_read,
  input  logic              req_burst,
  input  logic [1:0]        req_psize,
  input  logic              bus_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_read,
  output logic              bus_burst,
  output logic              bus_start,
  output logic              bus_active,
  output logic              xfer_done
);
  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int CNT_W = OFS_W;

  logic             accept, beat_adv, finish, busy, last;
  logic [CNT_W-1:0] beat, limit;

  cwf_ctl u_ctl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ack(bus_ack), .last(last),
    .accept(accept), .beat_adv(beat_adv), .finish(finish), .busy(busy),
    .start(bus_start), .done(xfer_done)
  );

  cwf_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .load(accept), .limit_in(limit), .adv(beat_adv),
    .beat(beat), .last(last)
  );

  cwf_addr_gen #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst(rst), .load(accept), .req_addr(req_addr), .req_read(req_read),
    .req_burst(req_burst), .req_psize(req_psize), .active(busy), .ack(bus_ack),
    .last(last), .beat(beat), .limit(limit), .bus_addr(bus_addr),
    .bus_read(bus_read), .bus_burst(bus_burst)
  );

  assign bus_active = busy;

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) xfer_done |-> !bus_active);
  // R4
  busy_req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    bus_active && req_valid |=> !bus_start);

endmodule

// File: tb/test_cwf_burst_seq.sv
`timescale 1ns/1ps
module test_cwf_burst_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [25:0] req_addr = '0;
  logic        req_read = 1'b0;
  logic        req_burst = 1'b0;
  logic [1:0]  req_psize = 2'b00;
  logic        bus_ack = 1'b0;
  logic [25:0] bus_addr;
  logic        bus_read, bus_burst, bus_start, bus_active, xfer_done;

  always #4 clk = ~clk;

  cwf_burst_seq i_cwf_burst_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_read(req_read), .req_burst(req_burst), .req_psize(req_psize),
    .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_read(bus_read),
    .bus_burst(bus_burst), .bus_start(bus_start), .bus_active(bus_active),
    .xfer_done(xfer_done)
  );

  typedef struct {
    logic [25:0] a;
    logic        rd;
    logic        bu;
    logic        last;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int issued = 0;
  int starts = 0;
  int ack_mode = 0;
  int ack_cnt = 0;
  bit expect_done = 0;
  bit prev_active = 0;
  bit mon_on = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // acknowledge pattern, changed shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      ack_cnt++;
      case (ack_mode)
        0: bus_ack = 1'b1;
        1: bus_ack = (ack_cnt % 3 == 0);
        default: bus_ack = 1'b0;
      endcase
    end
  end

  // monitor: pops expected beats as the design presents acknowledged ones
  always @(negedge clk) begin
    if (mon_on) begin
      if (expect_done) begin
        check(xfer_done === 1'b1 && bus_active === 1'b0, "R8", "done pulse / idle",
              {30'd0, xfer_done, bus_active}, 32'h2);
        expect_done = 0;
      end else if (xfer_done !== 1'b0) begin
        check(1'b0, "R8", "unexpected done", 32'(xfer_done), 32'd0);
      end
      if (bus_start === 1'b1) starts++;
      if (bus_active === 1'b1 && !prev_active)
        check(bus_start === 1'b1, "R4", "start on first cycle", 32'(bus_start), 32'd1);
      else if (bus_start !== 1'b0)
        check(1'b0, "R4", "start outside first cycle", 32'(bus_start), 32'd0);
      if (bus_active === 1'b1 && bus_ack === 1'b1) begin
        if (q.size() == 0) begin
          check(1'b0, "R6", "beat with empty scoreboard", 32'(bus_addr), 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(bus_addr === e.a, e.tag, "beat address", 32'(bus_addr), 32'(e.a));
          check(bus_read === e.rd && bus_burst === e.bu, "R3", "read/burst attrs",
                {30'd0, bus_read, bus_burst}, {30'd0, e.rd, e.bu});
          if (e.last) expect_done = 1;
        end
      end
      prev_active = (bus_active === 1'b1);
    end
  end

  // driver: waits for an idle slot, pushes expected beats, issues the request
  task automatic issue(input logic [25:0] addr, input bit rd, input bit bu,
                       input logic [1:0] ps, input string tag, input bit poke_busy);
    int unsigned step;
    int unsigned nb;
    logic [3:0] ofs;
    do begin
      @(negedge clk); #1;
    end while (bus_active || q.size() != 0);
    step = (ps == 2'b01) ? 1 : (ps == 2'b10) ? 2 : 4;
    nb   = bu ? 16 / step : 1;
    ofs  = addr[3:0];
    for (int i = 0; i < int'(nb); i++) begin
      exp_t e;
      e.a = {addr[25:4], ofs};
      e.rd = rd; e.bu = bu; e.last = (i == int'(nb) - 1); e.tag = tag;
      q.push_back(e);
      ofs = ofs + 4'(step);
    end
    issued++;
    req_addr = addr; req_read = rd; req_burst = bu; req_psize = ps;
    req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    if (poke_busy) begin
      // R4: requests while busy must not disturb the running transfer
      while (bus_active) begin
        req_addr = 26'h3ABCDEF; req_read = ~rd; req_burst = ~bu; req_psize = 2'b01;
        req_valid = 1'b1;
        @(negedge clk); #1;
      end
      req_valid = 1'b0;
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((q.size() != 0 || bus_active || expect_done) && n < 200) begin
      @(negedge clk); #1; n++;
    end
    @(negedge clk); #1;
  endtask

  task automatic run_all();
    ack_mode = 2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bus_active === 1'b0 && bus_start === 1'b0 && xfer_done === 1'b0, "R1",
          "strobes in reset", {29'd0, bus_active, bus_start, xfer_done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(bus_addr === 26'd0 && bus_read === 1'b0 && bus_burst === 1'b0, "R1",
          "idle address/attrs", 32'(bus_addr), 32'd0);
    check(bus_active === 1'b0 && xfer_done === 1'b0, "R1", "idle after reset",
          {30'd0, bus_active, xfer_done}, 32'd0);
    mon_on = 1;

    ack_mode = 0;
    issue(26'h1234568, 1'b1, 1'b1, 2'b00, "R5", 1'b0);     // 32-bit, crit 8
    ack_mode = 1;
    issue(26'h0ABCDE6, 1'b0, 1'b1, 2'b10, "R6", 1'b1);     // 16-bit, crit 6, slow ack
    issue(26'h2FFFFFF, 1'b1, 1'b1, 2'b01, "R5", 1'b0);     // 8-bit, crit 15
    issue(26'h0001237, 1'b0, 1'b0, 2'b00, "R7", 1'b1);     // single beat
    ack_mode = 0;
    issue(26'h3000004, 1'b1, 1'b1, 2'b11, "R5", 1'b0);     // reserved code
    issue(26'h155555D, 1'b0, 1'b0, 2'b10, "R7", 1'b0);     // back-to-back
    issue(26'h2AAAAA2, 1'b1, 1'b1, 2'b10, "R8", 1'b0);
    drain();

    // R2: held beat under a stalled acknowledge
    ack_mode = 2;
    issue(26'h0C0FFE9, 1'b1, 1'b1, 2'b00, "R2", 1'b0);
    repeat (4) @(negedge clk);
    check(bus_addr === 26'h0C0FFE9 && bus_active === 1'b1, "R2", "held address in stall",
          32'(bus_addr), 32'h0C0FFE9);
    ack_mode = 0;
    drain();

    check(starts == issued, "R4", "start count", 32'(starts), 32'(issued));
    check(q.size() == 0, "R6", "scoreboard empty", 32'(q.size()), 32'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule